// File: doc/BRIEF.md
# Hub Downstream Link and Traffic Indicator

This block drives one active-low indicator per downstream port of a small USB hub. For each port it watches three one-cycle pulses from the packet decoder and a port-enabled flag. The pulses mark a good start of packet, a good end of packet, and an end that was aborted or malformed. A port's indicator stays dark until the port is enabled and has carried a complete, valid upstream packet. After that it glows steadily. Every further valid packet turns it off for a fixed number of clock cycles. A packet that arrives while the indicator is already off starts that off-time again from the beginning.

A global suspend flag darkens every indicator. The per-port state is kept through suspend, so each indicator comes back as it was when suspend ends. An alternate pin mode takes over the indicator pin of one selected port for another use, and that indicator is then held dark. Disabling a port erases its record of traffic, so after it is enabled again it stays dark until a new valid packet arrives. The output register resets to all dark.

Top module: `hub_link_led`

## Requirements
- R1: While reset is asserted, and after it is released until a valid packet is seen, every bit of `led_n_o` is 1 (dark).
- R2: Bit i of `led_n_o` drives port i. A value of 0 means lit. A port's bit becomes 0 on the clock edge that accepts its first valid packet after enable, and it does not blink for that first packet.
- R3: A packet is valid only if a `sop_good_i` pulse is followed by an `eop_good_i` pulse on the same port. An `eop_good_i` pulse with no open packet does not count. An `eop_bad_i` pulse closes the open packet without counting it.
- R4: Each valid packet on a port that has already seen traffic drives its bit to 1 for exactly BLINK_CYC cycles. The bit then returns to 0.
- R5: A valid packet that arrives while its port is blinking reloads the full BLINK_CYC off-time.
- R6: When `port_en_i[i]` is 0, bit i is 1 from the next edge on. The port's traffic record and any open packet are cleared, and start pulses are ignored. After the port is enabled again, it stays dark until a new valid packet arrives.
- R7: While `suspend_i` is 1, every bit is 1 from the next edge on. When `suspend_i` falls, each bit returns to the value that its retained state selects.
- R8: While `alt_pin_mode_i` is 1, the bit of port ALT_PORT (by default the highest port, bit NPORT-1) is held at 1. The other ports are not affected.
- R9: Ports are independent. Pulses on one port never change another port's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en_i | input | NPORT | Per-port enabled flag |
| sop_good_i | input | NPORT | One-cycle pulse: good start of packet |
| eop_good_i | input | NPORT | One-cycle pulse: good end of packet |
| eop_bad_i | input | NPORT | One-cycle pulse: packet aborted or bad end |
| suspend_i | input | 1 | Global suspend, forces all indicators dark |
| alt_pin_mode_i | input | 1 | Alternate pin mode, darkens port ALT_PORT |
| led_n_o | output | NPORT | Active-low indicators, bit i for port i |

## Verification
The bench builds the block with NPORT=2 and BLINK_CYC=4, and ALT_PORT keeps its default of 1. An off-time of four cycles lets the bench count every cycle of a blink and reach the reload case within a few vectors. With two ports it can check independence and alternate pin mode on the same run. A blink started just before reset, and one started just before suspend, test how those two overrides interact with a running counter.

// File: rtl/hub_led_pkg.sv
package hub_led_pkg;

    // Per-port traffic bookkeeping: an open packet and the seen-traffic flag.
    typedef struct packed {
        logic in_pkt;
        logic seen;
    } trk_t;

endpackage

// File: rtl/led_port_track.sv
module led_port_track
    import hub_led_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sop_i,
    input  logic eop_ok_i,
    input  logic eop_bad_i,
    output logic seen_next_o,
    output logic retrig_o
);

    trk_t trk_d, trk_q;
    logic hit;

    // A packet counts only when a good end closes an open packet.
    assign hit = en_i & eop_ok_i & trk_q.in_pkt;

    always_comb begin
        trk_d = trk_q;
        if (!en_i) begin
            trk_d = '0;
        end else begin
            if (sop_i)
                trk_d.in_pkt = 1'b1;
            else if (eop_ok_i || eop_bad_i)
                trk_d.in_pkt = 1'b0;
            if (hit)
                trk_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign seen_next_o = trk_d.seen;
    assign retrig_o    = hit & trk_q.seen;

    // R3: a bad end leaves no packet open.
    p_abort_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && eop_bad_i && !sop_i) |=> !trk_q.in_pkt);

    // R2: the first valid packet records traffic.
    p_first_hit_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && eop_ok_i && trk_q.in_pkt) |=> trk_q.seen);

    // R6: disabling clears the record.
    p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (trk_q == '0));

endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
    parameter int BLINK_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic load_i,
    output logic idle_next_o
);

    localparam int CW = $clog2(BLINK_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(BLINK_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clr_i)
            tmr_d.cnt = '0;
        else if (load_i)
            tmr_d.cnt = LOAD_VAL;
        else if (tmr_q.cnt != '0)
            tmr_d.cnt = tmr_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign idle_next_o = (tmr_d.cnt == '0);

    // R5: every retrigger reloads the full off-time.
    p_reload_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> (tmr_q.cnt == LOAD_VAL));

    // R4: a running off-time counts down by one each cycle.
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.cnt != '0 && !load_i && !clr_i) |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1));

endmodule

// File: rtl/hub_link_led.sv
module hub_link_led #(
    parameter int NPORT     = 2,
    parameter int BLINK_CYC = 50000,
    parameter int ALT_PORT  = NPORT - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] port_en_i,
    input  logic [NPORT-1:0] sop_good_i,
    input  logic [NPORT-1:0] eop_good_i,
    input  logic [NPORT-1:0] eop_bad_i,
    input  logic             suspend_i,
    input  logic             alt_pin_mode_i,
    output logic [NPORT-1:0] led_n_o
);

    typedef struct packed {
        logic [NPORT-1:0] led_n;
    } out_t;

    out_t out_d, out_q;
    logic [NPORT-1:0] seen_next, retrig, idle_next, lit;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        led_port_track u_track (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (port_en_i[g]),
            .sop_i      (sop_good_i[g]),
            .eop_ok_i   (eop_good_i[g]),
            .eop_bad_i  (eop_bad_i[g]),
            .seen_next_o(seen_next[g]),
            .retrig_o   (retrig[g])
        );

        led_blink_timer #(.BLINK_CYC(BLINK_CYC)) u_timer (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr_i      (!port_en_i[g]),
            .load_i     (retrig[g]),
            .idle_next_o(idle_next[g])
        );

        // Alternate pin mode removes the indicator of ALT_PORT.
        if (g == ALT_PORT) begin : g_alt
            assign lit[g] = port_en_i[g] & seen_next[g] & idle_next[g]
                            & !suspend_i & !alt_pin_mode_i;
        end else begin : g_std
            assign lit[g] = port_en_i[g] & seen_next[g] & idle_next[g] & !suspend_i;
        end

        // R6: a disabled port is dark from the next edge.
        p_disabled_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !port_en_i[g] |=> led_n_o[g]);
    end

    always_comb begin
        out_d       = out_q;
        out_d.led_n = ~lit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{led_n: '1};
        else        out_q <= out_d;
    end

    assign led_n_o = out_q.led_n;

    // R7: suspend darkens every indicator.
    p_suspend_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_i |=> (&led_n_o));

    // R8: alternate pin mode darkens the selected port.
    p_alt_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alt_pin_mode_i |=> led_n_o[ALT_PORT]);

endmodule

// File: tb/tb_hub_link_led.sv
`timescale 1ns/1ps
module tb_hub_link_led;

    localparam int NP = 2;
    localparam int BC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] en = '0, sop = '0, eok = '0, ebad = '0;
    logic          susp = 1'b0, alt = 1'b0;
    logic [NP-1:0] led_n;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hub_link_led #(.NPORT(NP), .BLINK_CYC(BC)) dut (
        .clk(clk), .rst_n(rst_n), .port_en_i(en), .sop_good_i(sop),
        .eop_good_i(eok), .eop_bad_i(ebad), .suspend_i(susp),
        .alt_pin_mode_i(alt), .led_n_o(led_n)
    );

    // Vector fields: {en[1:0], sop[1:0], eok[1:0], ebad[1:0], susp, alt, exp_led_n[1:0]}
    // exp is the indicator after the edge that accepts the vector (0 = lit).
    localparam int NV = 33;
    localparam logic [11:0] VEC [NV] = '{
        12'b11_00_00_00_0_0_11, // 0  R2 enabled, no traffic: dark
        12'b11_00_01_00_0_0_11, // 1  R3 end without start ignored
        12'b11_01_00_00_0_0_11, // 2  R3 start p0
        12'b11_00_00_01_0_0_11, // 3  R3 abort not counted
        12'b11_01_00_00_0_0_11, // 4  start p0
        12'b11_00_01_00_0_0_10, // 5  R2 first valid: p0 lit, no blink
        12'b11_11_00_00_0_0_10, // 6  start both
        12'b11_00_11_00_0_0_01, // 7  R4 p0 blinks, R9 p1 first lit
        12'b11_00_00_00_0_0_01, // 8  R4 off 2
        12'b11_00_00_00_0_0_01, // 9  R4 off 3
        12'b11_00_00_00_0_0_01, // 10 R4 off 4
        12'b11_00_00_00_0_0_00, // 11 R4 back on after BC cycles
        12'b11_01_00_00_0_0_00, // 12 start p0
        12'b11_00_01_00_0_0_01, // 13 R5 blink
        12'b11_01_00_00_0_0_01, // 14 start during blink
        12'b11_00_01_00_0_0_01, // 15 R5 reload
        12'b11_00_00_00_0_0_01, // 16
        12'b11_00_00_00_0_0_01, // 17 R5 still off (would be on without reload)
        12'b11_00_00_00_0_0_01, // 18 R5
        12'b11_00_00_00_0_0_00, // 19 R5 on after reloaded off-time
        12'b11_00_00_00_1_0_11, // 20 R7 suspend dark
        12'b11_00_00_00_1_0_11, // 21 R7
        12'b11_00_00_00_0_0_00, // 22 R7 restored
        12'b11_00_00_00_0_1_10, // 23 R8 alt darkens port 1
        12'b11_00_00_00_0_0_00, // 24 R8 released
        12'b10_00_00_00_0_0_01, // 25 R6 p0 disabled
        12'b11_00_00_00_0_0_01, // 26 R6 re-enabled, still dark
        12'b11_01_00_00_0_0_01, // 27 start p0
        12'b11_00_01_00_0_0_00, // 28 R6 new valid: lit, no blink
        12'b10_01_00_00_0_0_01, // 29 R6 start while disabled ignored
        12'b11_00_01_00_0_0_01, // 30 R6/R3 end without accepted start
        12'b11_01_00_00_0_0_01, // 31 start p0
        12'b11_00_01_00_0_0_00  // 32 R9 lit again, p1 untouched
    };

    task automatic chk(input logic [NP-1:0] exp, input string tag);
        n_run++;
        if (led_n !== exp) begin
            n_fail++;
            $display("FAIL %s: led_n=%b expected %b", tag, led_n, exp);
        end
    endtask

    task automatic drive(input logic [NP-1:0] e, s, ok, bad, input logic sp, al);
        en = e; sop = s; eok = ok; ebad = bad; susp = sp; alt = al;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(2'b11, "R1 during reset");
        en = 2'b11;
        @(negedge clk);
        chk(2'b11, "R1 reset held with ports enabled");
        rst_n = 1'b1;
        @(negedge clk);
        chk(2'b11, "R1 after reset release");

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][11:10], VEC[v][9:8], VEC[v][7:6], VEC[v][5:4],
                  VEC[v][3], VEC[v][2]);
            chk(VEC[v][1:0], $sformatf("vector %0d (R2..R9 per table)", v));
        end

        // R1: reset in the middle of a blink
        drive(2'b11, 2'b10, 2'b00, 2'b00, 1'b0, 1'b0);
        drive(2'b11, 2'b00, 2'b10, 2'b00, 1'b0, 1'b0);
        chk(2'b10, "R4 p1 blink before reset");
        rst_n = 1'b0;
        @(negedge clk);
        chk(2'b11, "R1 reset during blink");
        rst_n = 1'b1;
        repeat (BC + 2) drive(2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0);
        chk(2'b11, "R1 traffic record cleared by reset");

        // R7: suspend over a running blink, restore after it expires
        drive(2'b11, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0);
        drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b0, 1'b0);
        chk(2'b00, "R2 both first packets lit");
        drive(2'b11, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0);
        drive(2'b11, 2'b00, 2'b01, 2'b00, 1'b0, 1'b0);
        chk(2'b01, "R4 p0 blink before suspend");
        drive(2'b11, 2'b00, 2'b00, 2'b00, 1'b1, 1'b0);
        chk(2'b11, "R7 suspend during blink");
        repeat (BC) drive(2'b11, 2'b00, 2'b00, 2'b00, 1'b1, 1'b0);
        chk(2'b11, "R7 suspend held");
        drive(2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0);
        chk(2'b00, "R7 both restored after suspend");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule